// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the settings of a PLL without software pacing. A single start strobe carries three requested values: a pre-divider, a multiplier and a post-divider. Two capability flags tell whether the target PLL has a pre-divider register and a post-divider register. The sequencer then issues a fixed series of one-cycle register writes to the PLL control block, with counted waits between some of the writes. It raises busy for the whole series and pulses done together with the last write.

The series runs in this order. The PLL is put into bypass, and the bypass delay follows. The PLL is placed in reset and powered up. The divider and multiplier words are written. After a reset hold time, the PLL is released from reset. The sequencer then waits for lock, and the lock time grows with the requested pre-divider. Last, the PLL leaves bypass.

All control-register writes are read-modify-write on a shadow copy kept inside the block. Bits that the sequence never touches keep the value they had before the write.

Top module: `pll_reprog_seq`

## Requirements
- R1: A synchronous reset clears busy, done and wr_en, and loads the control shadow with CTL_INIT (default 0x012B). After reset, with no start, all three outputs stay low.
- R2: A start seen while busy is low is accepted. In the next cycle busy is high, and a write to ADDR_CTL carries the shadow with the enable bit (BIT_EN, default 0) and the enable-source bit (BIT_SRC, default 5) cleared.
- R3: Exactly BYPASS_CYC cycles with wr_en low follow the bypass write. Then one ADDR_CTL write carries the shadow with the reset bit (BIT_RST, default 3) and the power-down bit (BIT_PDN, default 1) cleared.
- R4: In the cycles directly after the reset-entry write, the block writes ADDR_PRE only when has_pre was set at start. It always writes ADDR_MUL, and it writes ADDR_POST only when has_post was set at start. The writes come in that order and on consecutive cycles.
- R5: A divider request of 0 is written as 0. A divider request N>0 is written as (N-1) with bit DIV_EN_BIT (default 15) set. A multiplier request of 0 is written as 0, and a request M>0 is written as M-1 without the enable bit.
- R6: Exactly RESET_CYC cycles with wr_en low follow the last divider write. Then one ADDR_CTL write sets BIT_RST in the shadow.
- R7: After the reset-release write, the number of cycles with wr_en low is ((LOCK_NUM*P)/LOCK_DEN)*CYC_PER_UNIT when the requested pre-divider P is nonzero. This holds whether has_pre is set or not. When P is 0, the count is DEFLOCK_CYC.
- R8: The last write goes to ADDR_CTL with BIT_EN set in the shadow. done is high in that write's cycle only, and busy is low in the following cycle.
- R9: A start, and any change of the request inputs, is ignored while busy is high, including the cycle of the final write.
- R10: Shadow bits other than the four control bits never change. The shadow carries over from one sequence to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when not busy |
| pre_req | input | VAL_W | Requested pre-divider (0 = off) |
| mul_req | input | VAL_W | Requested multiplier (0 = times one) |
| post_req | input | VAL_W | Requested post-divider (0 = off) |
| has_pre | input | 1 | Target has a pre-divider register |
| has_post | input | 1 | Target has a post-divider register |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulses with the final write |

## Verification
Requests are run with both capability flags set, with neither set, and with only the pre-divider present.

- The flag mixtures separate the optional writes from the mandatory multiplier write, and they check that the reset hold is counted from whichever divider write comes last.
- Zero values for every request show the disabled encodings and the fall-back to the default lock time. A zero pre-divider with has_pre clear, next to a nonzero one, shows that the lock time follows the request and not the flag.
- Holding start high through whole runs, while the request values change, checks that nothing is taken while busy. It also checks that a new run begins in the first idle cycle after done.
- A reset in the middle of a run shows that the shadow returns to its initial value.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_BYP_WAIT,
    SQ_DIV_FIRST,
    SQ_MUL,
    SQ_POST,
    SQ_RST_WAIT,
    SQ_LOCK_WAIT,
    SQ_FIN
  } seq_state_e;

endpackage

// File: rtl/pll_seq_divword.sv
module pll_seq_divword #(
  parameter int unsigned VAL_W      = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DIV_EN_BIT = 15
) (
  input  logic [VAL_W-1:0]  val,
  output logic [DATA_W-1:0] word
);

  localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << DIV_EN_BIT;

  logic [VAL_W-1:0] dec;

  assign dec  = val - VAL_W'(1);
  assign word = (val == '0) ? '0 : (DATA_W'(dec) | EN_MASK);

endmodule

// File: rtl/pll_seq_encode.sv
module pll_seq_encode #(
  parameter int unsigned VAL_W        = 8,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DIV_EN_BIT   = 15,
  parameter int unsigned TMR_W        = 16,
  parameter int unsigned LOCK_NUM     = 2000,
  parameter int unsigned LOCK_DEN     = 100,
  parameter int unsigned CYC_PER_UNIT = 2,
  parameter int unsigned DEFLOCK_CYC  = 10
) (
  input  logic [VAL_W-1:0]  pre_val,
  input  logic [VAL_W-1:0]  mul_val,
  input  logic [VAL_W-1:0]  post_val,
  output logic [DATA_W-1:0] pre_word,
  output logic [DATA_W-1:0] mul_word,
  output logic [DATA_W-1:0] post_word,
  output logic [TMR_W-1:0]  lock_cycles
);

  localparam int unsigned NDIV = 2;

  logic [NDIV-1:0][VAL_W-1:0]  div_in;
  logic [NDIV-1:0][DATA_W-1:0] div_out;
  logic [VAL_W-1:0]            mul_dec;

  assign div_in[0] = pre_val;
  assign div_in[1] = post_val;

  // both dividers share one encoding
  for (genvar g = 0; g < NDIV; g++) begin : g_div
    pll_seq_divword #(
      .VAL_W     (VAL_W),
      .DATA_W    (DATA_W),
      .DIV_EN_BIT(DIV_EN_BIT)
    ) u_word (
      .val (div_in[g]),
      .word(div_out[g])
    );
  end

  assign pre_word  = div_out[0];
  assign post_word = div_out[1];

  // multiplier: zero and one both map to zero, no enable flag
  assign mul_dec  = mul_val - VAL_W'(1);
  assign mul_word = (mul_val == '0) ? '0 : DATA_W'(mul_dec);

  // lock wait depends on the requested pre-divider, not on the capability
  assign lock_cycles = (pre_val != '0)
    ? TMR_W'(((32'(LOCK_NUM) * 32'(pre_val)) / 32'(LOCK_DEN)) * 32'(CYC_PER_UNIT))
    : TMR_W'(DEFLOCK_CYC);

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned VAL_W       = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned ADDR_CTL    = 0,
  parameter int unsigned ADDR_PRE    = 1,
  parameter int unsigned ADDR_MUL    = 2,
  parameter int unsigned ADDR_POST   = 3,
  parameter int unsigned BIT_EN      = 0,
  parameter int unsigned BIT_SRC     = 5,
  parameter int unsigned BIT_RST     = 3,
  parameter int unsigned BIT_PDN     = 1,
  parameter int unsigned CTL_INIT    = 'h012B,
  parameter int unsigned BYPASS_CYC  = 4,
  parameter int unsigned RESET_CYC   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VAL_W-1:0]  pre_in,
  input  logic [VAL_W-1:0]  mul_in,
  input  logic [VAL_W-1:0]  post_in,
  input  logic              has_pre,
  input  logic              has_post,
  input  logic [DATA_W-1:0] pre_word,
  input  logic [DATA_W-1:0] mul_word,
  input  logic [DATA_W-1:0] post_word,
  input  logic [TMR_W-1:0]  lock_cycles,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic [VAL_W-1:0]  req_pre_q,
  output logic [VAL_W-1:0]  req_mul_q,
  output logic [VAL_W-1:0]  req_post_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);

  localparam logic [DATA_W-1:0] M_EN   = DATA_W'(1) << BIT_EN;
  localparam logic [DATA_W-1:0] M_SRC  = DATA_W'(1) << BIT_SRC;
  localparam logic [DATA_W-1:0] M_RST  = DATA_W'(1) << BIT_RST;
  localparam logic [DATA_W-1:0] M_PDN  = DATA_W'(1) << BIT_PDN;
  localparam logic [DATA_W-1:0] SH_RST = DATA_W'(CTL_INIT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(ADDR_PRE);
  localparam logic [ADDR_W-1:0] A_MUL  = ADDR_W'(ADDR_MUL);
  localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(ADDR_POST);

  seq_state_e        st_q, st_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              has_pre_q, has_post_q;
  logic              latch;
  logic              issue_mul;
  logic              we_n, done_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    st_n      = st_q;
    sh_n      = sh_q;
    we_n      = 1'b0;
    done_n    = 1'b0;
    addr_n    = wr_addr;
    data_n    = wr_data;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    latch     = 1'b0;
    issue_mul = 1'b0;

    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          latch    = 1'b1;
          sh_n     = sh_q & ~(M_EN | M_SRC);
          we_n     = 1'b1;
          addr_n   = A_CTL;
          data_n   = sh_n;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(BYPASS_CYC);
          st_n     = SQ_BYP_WAIT;
        end
      end
      SQ_BYP_WAIT: begin
        if (tmr_expired) begin
          sh_n   = sh_q & ~(M_RST | M_PDN);
          we_n   = 1'b1;
          addr_n = A_CTL;
          data_n = sh_n;
          st_n   = SQ_DIV_FIRST;
        end
      end
      SQ_DIV_FIRST: begin
        if (has_pre_q) begin
          we_n   = 1'b1;
          addr_n = A_PRE;
          data_n = pre_word;
          st_n   = SQ_MUL;
        end else begin
          issue_mul = 1'b1;
        end
      end
      SQ_MUL: begin
        issue_mul = 1'b1;
      end
      SQ_POST: begin
        we_n     = 1'b1;
        addr_n   = A_POST;
        data_n   = post_word;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RESET_CYC);
        st_n     = SQ_RST_WAIT;
      end
      SQ_RST_WAIT: begin
        if (tmr_expired) begin
          sh_n     = sh_q | M_RST;
          we_n     = 1'b1;
          addr_n   = A_CTL;
          data_n   = sh_n;
          tmr_load = 1'b1;
          tmr_val  = lock_cycles;
          st_n     = SQ_LOCK_WAIT;
        end
      end
      SQ_LOCK_WAIT: begin
        if (tmr_expired) begin
          sh_n   = sh_q | M_EN;
          we_n   = 1'b1;
          addr_n = A_CTL;
          data_n = sh_n;
          done_n = 1'b1;
          st_n   = SQ_FIN;
        end
      end
      SQ_FIN: begin
        st_n = SQ_IDLE;
      end
      default: begin
        st_n = SQ_IDLE;
      end
    endcase

    // multiplier write is common to two states
    if (issue_mul) begin
      we_n   = 1'b1;
      addr_n = A_MUL;
      data_n = mul_word;
      if (has_post_q) begin
        st_n = SQ_POST;
      end else begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RESET_CYC);
        st_n     = SQ_RST_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      sh_q       <= SH_RST;
      has_pre_q  <= 1'b0;
      has_post_q <= 1'b0;
      req_pre_q  <= '0;
      req_mul_q  <= '0;
      req_post_q <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
    end else begin
      st_q    <= st_n;
      sh_q    <= sh_n;
      wr_en   <= we_n;
      wr_addr <= addr_n;
      wr_data <= data_n;
      done    <= done_n;
      if (latch) begin
        has_pre_q  <= has_pre;
        has_post_q <= has_post;
        req_pre_q  <= pre_in;
        req_mul_q  <= mul_in;
        req_post_q <= post_in;
      end
    end
  end

  assign busy = (st_q != SQ_IDLE);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int unsigned VAL_W        = 8,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned ADDR_CTL     = 0,
  parameter int unsigned ADDR_PRE     = 1,
  parameter int unsigned ADDR_MUL     = 2,
  parameter int unsigned ADDR_POST    = 3,
  parameter int unsigned BIT_EN       = 0,
  parameter int unsigned BIT_SRC      = 5,
  parameter int unsigned BIT_RST      = 3,
  parameter int unsigned BIT_PDN      = 1,
  parameter int unsigned DIV_EN_BIT   = 15,
  parameter int unsigned CTL_INIT     = 'h012B,
  parameter int unsigned BYPASS_CYC   = 4,
  parameter int unsigned RESET_CYC    = 6,
  parameter int unsigned DEFLOCK_CYC  = 10,
  parameter int unsigned CYC_PER_UNIT = 2,
  parameter int unsigned LOCK_NUM     = 2000,
  parameter int unsigned LOCK_DEN     = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VAL_W-1:0]  pre_req,
  input  logic [VAL_W-1:0]  mul_req,
  input  logic [VAL_W-1:0]  post_req,
  input  logic              has_pre,
  input  logic              has_post,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);

  localparam int unsigned LOCK_MAX =
    ((LOCK_NUM * ((2 ** VAL_W) - 1)) / LOCK_DEN) * CYC_PER_UNIT;
  localparam int unsigned MAX_AB   = (BYPASS_CYC > RESET_CYC) ? BYPASS_CYC : RESET_CYC;
  localparam int unsigned MAX_ABC  = (MAX_AB > DEFLOCK_CYC) ? MAX_AB : DEFLOCK_CYC;
  localparam int unsigned TMR_MAX  = (MAX_ABC > LOCK_MAX) ? MAX_ABC : LOCK_MAX;
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1) + 1;

  logic [VAL_W-1:0]  req_pre_q, req_mul_q, req_post_q;
  logic [DATA_W-1:0] pre_word, mul_word, post_word;
  logic [TMR_W-1:0]  lock_cycles, tmr_val;
  logic              tmr_load, tmr_expired;

  pll_seq_encode #(
    .VAL_W       (VAL_W),
    .DATA_W      (DATA_W),
    .DIV_EN_BIT  (DIV_EN_BIT),
    .TMR_W       (TMR_W),
    .LOCK_NUM    (LOCK_NUM),
    .LOCK_DEN    (LOCK_DEN),
    .CYC_PER_UNIT(CYC_PER_UNIT),
    .DEFLOCK_CYC (DEFLOCK_CYC)
  ) u_enc (
    .pre_val    (req_pre_q),
    .mul_val    (req_mul_q),
    .post_val   (req_post_q),
    .pre_word   (pre_word),
    .mul_word   (mul_word),
    .post_word  (post_word),
    .lock_cycles(lock_cycles)
  );

  pll_seq_timer #(
    .TMR_W(TMR_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pll_seq_ctrl #(
    .VAL_W     (VAL_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TMR_W     (TMR_W),
    .ADDR_CTL  (ADDR_CTL),
    .ADDR_PRE  (ADDR_PRE),
    .ADDR_MUL  (ADDR_MUL),
    .ADDR_POST (ADDR_POST),
    .BIT_EN    (BIT_EN),
    .BIT_SRC   (BIT_SRC),
    .BIT_RST   (BIT_RST),
    .BIT_PDN   (BIT_PDN),
    .CTL_INIT  (CTL_INIT),
    .BYPASS_CYC(BYPASS_CYC),
    .RESET_CYC (RESET_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pre_in     (pre_req),
    .mul_in     (mul_req),
    .post_in    (post_req),
    .has_pre    (has_pre),
    .has_post   (has_post),
    .pre_word   (pre_word),
    .mul_word   (mul_word),
    .post_word  (post_word),
    .lock_cycles(lock_cycles),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .req_pre_q  (req_pre_q),
    .req_mul_q  (req_mul_q),
    .req_post_q (req_post_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/pll_seq_checker.sv
module pll_seq_checker #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_CTL = 0,
  parameter int unsigned BIT_EN   = 0,
  parameter int unsigned BIT_SRC  = 5,
  parameter int unsigned BIT_RST  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              done
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

  assert_start_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && wr_en && wr_addr == A_CTL &&
                          !wr_data[BIT_EN] && !wr_data[BIT_SRC]));

  assert_write_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  assert_enable_after_release_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTL && wr_data[BIT_EN]) |-> wr_data[BIT_RST]);

  assert_done_final_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && wr_en && wr_addr == A_CTL && wr_data[BIT_EN]));

  assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !done));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

bind pll_reprog_seq pll_seq_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ADDR_CTL(ADDR_CTL),
  .BIT_EN  (BIT_EN),
  .BIT_SRC (BIT_SRC),
  .BIT_RST (BIT_RST)
) u_pll_seq_checker (.*);

// File: tb/test_pll_reprog_seq.sv
`timescale 1ns/1ps
module test_pll_reprog_seq;

  localparam int A_CTL = 0, A_PRE = 4, A_MUL = 8, A_POST = 9;
  localparam int B_EN = 0, B_SRC = 5, B_RST = 3, B_PDN = 1, B_DEN = 15;
  localparam int INIT = 'h012B;
  localparam int BYP = 4, RSTC = 6, DEFL = 10, CPU = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] pre_req = '0, mul_req = '0, post_req = '0;
  logic       has_pre = 1'b0, has_post = 1'b0;
  logic       wr_en, busy, done;
  logic [3:0] wr_addr;
  logic [15:0] wr_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  pll_reprog_seq #(
    .VAL_W(8), .ADDR_W(4), .DATA_W(16),
    .ADDR_CTL(A_CTL), .ADDR_PRE(A_PRE), .ADDR_MUL(A_MUL), .ADDR_POST(A_POST),
    .BIT_EN(B_EN), .BIT_SRC(B_SRC), .BIT_RST(B_RST), .BIT_PDN(B_PDN),
    .DIV_EN_BIT(B_DEN), .CTL_INIT(INIT),
    .BYPASS_CYC(BYP), .RESET_CYC(RSTC), .DEFLOCK_CYC(DEFL),
    .CYC_PER_UNIT(CPU), .LOCK_NUM(2000), .LOCK_DEN(100)
  ) i_pll_reprog_seq (
    .clk(clk), .rst(rst), .start(start),
    .pre_req(pre_req), .mul_req(mul_req), .post_req(post_req),
    .has_pre(has_pre), .has_post(has_post),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  // expected outputs per cycle
  typedef struct packed {
    logic        b;
    logic        we;
    logic [3:0]  a;
    logic [15:0] d;
    logic        dn;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];
  int   sh = INIT;

  function automatic int enc_div(input int n);
    return (n == 0) ? 0 : ((n - 1) | (1 << B_DEN));
  endfunction

  function automatic int enc_mul(input int n);
    return (n == 0) ? 0 : (n - 1);
  endfunction

  task automatic push(input bit we, input int a, input int d, input bit dn, input int tag);
    exp_t e;
    e.b = 1'b1; e.we = we; e.a = 4'(a); e.d = 16'(d); e.dn = dn; e.tag = 8'(tag);
    q.push_back(e);
  endtask

  task automatic build(input int p, input int m, input int qv, input bit hp, input bit hq);
    int lk;
    sh = sh & ~((1 << B_EN) | (1 << B_SRC));
    push(1, A_CTL, sh, 0, 2);                        // R2 bypass entry
    for (int i = 0; i < BYP; i++) push(0, 0, 0, 0, 3); // R3 bypass gap
    sh = sh & ~((1 << B_RST) | (1 << B_PDN));
    push(1, A_CTL, sh, 0, 3);                        // R3 reset entry
    if (hp) push(1, A_PRE, enc_div(p), 0, 5);        // R4 R5 pre word
    push(1, A_MUL, enc_mul(m), 0, 4);                // R4 R5 multiplier
    if (hq) push(1, A_POST, enc_div(qv), 0, 5);      // R4 R5 post word
    for (int i = 0; i < RSTC; i++) push(0, 0, 0, 0, 6); // R6 reset hold
    sh = sh | (1 << B_RST);
    push(1, A_CTL, sh, 0, 6);                        // R6 release
    lk = (p != 0) ? ((2000 * p) / 100) * CPU : DEFL;
    for (int i = 0; i < lk; i++) push(0, 0, 0, 0, 7);   // R7 lock wait
    sh = sh | (1 << B_EN);
    push(1, A_CTL, sh, 1, 8);                        // R8 final write, R10 shadow
  endtask

  task automatic step(input bit st, input int p, input int m, input int qv,
                      input bit hp, input bit hq);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '0; e.tag = 8'd1;                          // R1 idle, also R8 busy drop
    end
    total++;
    if (busy !== e.b || done !== e.dn || wr_en !== e.we ||
        (e.we && (wr_addr !== e.a || wr_data !== e.d))) begin
      bad++;
      $display("FAIL R%0d t=%0t got busy=%b done=%b we=%b a=%h d=%h exp busy=%b done=%b we=%b a=%h d=%h",
               e.tag, $time, busy, done, wr_en, wr_addr, wr_data,
               e.b, e.dn, e.we, e.a, e.d);
    end
    start = st; pre_req = 8'(p); mul_req = 8'(m); post_req = 8'(qv);
    has_pre = hp; has_post = hq;
    if (st && !e.b) build(p, m, qv, hp, hq);
  endtask

  // one request; while busy, start is held at 'hold' and junk values are shown (R9)
  task automatic run_one(input int p, input int m, input int qv, input bit hp,
                         input bit hq, input bit hold);
    step(1, p, m, qv, hp, hq);
    while (q.size() > 0) step(hold, p ^ 8'hA5, m ^ 8'h3C, qv ^ 8'h0F, !hp, !hq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    q.delete();
    sh = INIT;                                        // R1 shadow reload
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);                                          // R1 reset state
    run_one(5, 20, 2, 1, 1, 0);                       // both dividers present
    idle(2);
    run_one(0, 0, 0, 1, 1, 0);                        // R5 zero encodings, R7 default lock
    idle(2);
    run_one(3, 1, 9, 0, 0, 1);                        // R4 no optional writes, R7 p without flag, R9 held start
    run_one(1, 255, 7, 1, 0, 1);                      // back-to-back after done, pre only
    run_one(0, 4, 2, 0, 1, 0);                        // post only, default lock
    idle(2);
    run_one(255, 128, 255, 1, 1, 0);                  // largest values
    // mid-run reset: R1 R10 shadow returns to initial value
    step(1, 7, 7, 7, 1, 1);
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 0, 0);
    do_reset();
    idle(2);
    run_one(2, 6, 3, 1, 1, 0);
    idle(3);
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule